// File: doc/BRIEF.md
# Bitfield Extract and Insert Unit

This unit is the bitfield stage of a 64-bit integer execution pipeline. In a single registered cycle it either pulls a contiguous run of bits out of a source operand and right-aligns it, or writes the low bits of a source operand into a chosen window of the current destination value. Two 5-bit immediates, `lsb_i` and `msb_i`, describe the window. For the wide forms the operation code can add 32 to either immediate, so the window can lie anywhere in the 64-bit word.

Each form checks whether its window is legal. An illegal window or an unassigned operation code raises `fault_o` and holds `wen_o` low, so the pipeline can turn the instruction into a reserved-instruction trap. The 32-bit forms sign-extend their 32-bit result into the upper half. Inputs are sampled on a rising clock edge, and the result appears on the outputs after that edge. Reset is synchronous and active high.

Top module: `bfx_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs clear on that edge: `result_o`=0, `wen_o`=0, `fault_o`=0.
- R2: Op code 0 (narrow extract) faults when `lsb_i`+`msb_i` > 31. Here `msb_i` is the field width minus one.
- R3: Op code 0 returns bits `lsb_i`..`lsb_i+msb_i` of `src_i`, zero-extended. When `msb_i`=31 it returns `src_i[31:0]` sign-extended to 64 bits.
- R4: Op codes 2, 3 and 4 are wide extracts. Code 3 adds 32 to lsb and code 4 adds 32 to msb. After that adjustment, all three fault when lsb+msb > 63.
- R5: A legal wide extract returns `src_i` shifted right by the adjusted lsb and masked to msb+1 bits. When the adjusted msb is 63, no mask is applied.
- R6: Op code 1 (narrow insert) faults when `lsb_i` > `msb_i`. Otherwise it replaces bits `lsb_i`..`msb_i` of `dst_i[31:0]` with the low bits of `src_i`, and returns that 32-bit value sign-extended.
- R7: Op codes 5, 6 and 7 are wide inserts. Code 6 adds 32 to both lsb and msb, and code 7 adds 32 to msb only. All three fault when the adjusted lsb > adjusted msb.
- R8: A legal wide insert replaces bits lsb..msb of `dst_i` with the low msb-lsb+1 bits of `src_i`. All other bits keep their values from `dst_i`, and no sign extension is applied.
- R9: Op codes 8 to 15 always fault.
- R10: `wen_o` is high exactly when the previous edge sampled `in_valid_i` high with no fault. `fault_o` is high only for a sampled valid request. With `in_valid_i` low, both outputs are low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | A request is present this cycle |
| op_i | input | 4 | Operation code (see R2 to R9) |
| src_i | input | 64 | Source operand |
| dst_i | input | 64 | Current destination value, used by inserts |
| lsb_i | input | 5 | Low-position immediate |
| msb_i | input | 5 | Size or top-position immediate |
| result_o | output | 64 | Registered result, valid when wen_o is high |
| wen_o | output | 1 | Result should be written back |
| fault_o | output | 1 | Reserved-instruction fault |

## Verification
On every cycle, the in-RTL assertions check four things:
- a fault never comes with a write enable;
- unassigned codes always fault;
- an idle cycle produces neither output;
- narrow inserts and full-width narrow extracts always return a sign-extended upper half.

The exact bit values of each extract and insert can only be shown by the bench. The same holds for where every form's legality boundary sits after the +32 rebasing. The bench compares each output cycle against a bit-loop model over directed corner windows and a long random run.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  typedef enum logic [3:0] {
    OP_XN      = 4'd0,
    OP_IN      = 4'd1,
    OP_XW      = 4'd2,
    OP_XW_UPOS = 4'd3,
    OP_XW_USZ  = 4'd4,
    OP_IW      = 4'd5,
    OP_IW_UPOS = 4'd6,
    OP_IW_USZ  = 4'd7
  } bfx_op_e;
endpackage

// File: rtl/bfx_decode.sv
module bfx_decode #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 5,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [3:0]       op_i,
  input  logic [IMM_W-1:0] lsb_i,
  input  logic [IMM_W-1:0] msb_i,
  output logic [IDX_W-1:0] lo_o,
  output logic [IDX_W-1:0] hi_o,
  output logic             is_ins_o,
  output logic             narrow_o,
  output logic             illegal_o
);
  import bfx_pkg::*;
  localparam int HALF = DATA_W / 2;
  localparam logic [IDX_W:0] NARROW_TOP = (IDX_W+1)'(HALF - 1);
  localparam logic [IDX_W:0] WIDE_TOP   = (IDX_W+1)'(DATA_W - 1);

  logic            up_lo, up_hi, known;
  logic [IDX_W:0]  span;

  always_comb begin
    up_lo    = 1'b0;
    up_hi    = 1'b0;
    is_ins_o = 1'b0;
    narrow_o = 1'b0;
    known    = 1'b1;
    unique case (op_i)
      OP_XN:      narrow_o = 1'b1;
      OP_IN:      begin narrow_o = 1'b1; is_ins_o = 1'b1; end
      OP_XW:      ;
      OP_XW_UPOS: up_lo = 1'b1;
      OP_XW_USZ:  up_hi = 1'b1;
      OP_IW:      is_ins_o = 1'b1;
      OP_IW_UPOS: begin is_ins_o = 1'b1; up_lo = 1'b1; up_hi = 1'b1; end
      OP_IW_USZ:  begin is_ins_o = 1'b1; up_hi = 1'b1; end
      default:    known = 1'b0;
    endcase
    lo_o = IDX_W'(lsb_i) + (up_lo ? IDX_W'(HALF) : '0);
    hi_o = IDX_W'(msb_i) + (up_hi ? IDX_W'(HALF) : '0);
    span = {1'b0, lo_o} + {1'b0, hi_o};
    if (!known)
      illegal_o = 1'b1;
    else if (is_ins_o)
      illegal_o = lo_o > hi_o;
    else if (narrow_o)
      illegal_o = span > NARROW_TOP;
    else
      illegal_o = span > WIDE_TOP;
  end
endmodule

// File: rtl/bfx_mask.sv
module bfx_mask #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [IDX_W-1:0]  top_i,
  output logic [DATA_W-1:0] mask_o
);
  localparam logic [IDX_W-1:0] TOP_MAX = IDX_W'(DATA_W - 1);
  // ones down to and including bit top_i; never shifts by DATA_W
  assign mask_o = {DATA_W{1'b1}} >> (TOP_MAX - top_i);
endmodule

// File: rtl/bfx_extract.sv
module bfx_extract #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [IDX_W-1:0]  lo_i,
  input  logic [IDX_W-1:0]  hi_i,
  input  logic              narrow_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int HALF = DATA_W / 2;
  logic [DATA_W-1:0] shifted, width_mask;

  bfx_mask #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_wmask (
    .top_i (hi_i),
    .mask_o(width_mask)
  );

  always_comb begin
    shifted = src_i >> lo_i;
    if (narrow_i && hi_i == IDX_W'(HALF - 1))
      res_o = {{HALF{shifted[HALF-1]}}, shifted[HALF-1:0]};
    else
      res_o = shifted & width_mask;
  end
endmodule

// File: rtl/bfx_insert.sv
module bfx_insert #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [IDX_W-1:0]  lo_i,
  input  logic [IDX_W-1:0]  hi_i,
  input  logic              narrow_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int HALF = DATA_W / 2;
  logic [DATA_W-1:0] upper_mask, field_mask, merged;

  bfx_mask #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_fmask (
    .top_i (hi_i),
    .mask_o(upper_mask)
  );

  always_comb begin
    field_mask = upper_mask & ({DATA_W{1'b1}} << lo_i);
    merged     = ((src_i << lo_i) & field_mask) | (dst_i & ~field_mask);
    res_o      = narrow_i ? {{HALF{merged[HALF-1]}}, merged[HALF-1:0]} : merged;
  end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [IMM_W-1:0]  lsb_i,
  input  logic [IMM_W-1:0]  msb_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wen_o,
  output logic              fault_o
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int HALF  = DATA_W / 2;

  logic [IDX_W-1:0]  lo, hi;
  logic              is_ins, narrow, illegal;
  logic [DATA_W-1:0] x_res, i_res;

  bfx_decode #(.DATA_W(DATA_W), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_dec (
    .op_i(op_i), .lsb_i(lsb_i), .msb_i(msb_i),
    .lo_o(lo), .hi_o(hi), .is_ins_o(is_ins), .narrow_o(narrow), .illegal_o(illegal)
  );

  bfx_extract #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ext (
    .src_i(src_i), .lo_i(lo), .hi_i(hi), .narrow_i(narrow), .res_o(x_res)
  );

  bfx_insert #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ins (
    .src_i(src_i), .dst_i(dst_i), .lo_i(lo), .hi_i(hi), .narrow_i(narrow), .res_o(i_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      wen_o    <= 1'b0;
      fault_o  <= 1'b0;
    end else begin
      result_o <= is_ins ? i_res : x_res;
      wen_o    <= in_valid_i && !illegal;
      fault_o  <= in_valid_i && illegal;
    end
  end

  // R10
  fault_no_wen_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> !wen_o);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !in_valid_i) |-> (!wen_o && !fault_o));
  // R9
  bad_code_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && in_valid_i && op_i[3]) |-> fault_o);
  // R6
  nins_sext_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && in_valid_i && op_i == 4'd1) && wen_o)
      |-> (result_o[DATA_W-1:HALF] == {HALF{result_o[HALF-1]}}));
  // R3
  next_full_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && in_valid_i && op_i == 4'd0 && msb_i == IMM_W'(HALF - 1)) && wen_o)
      |-> (result_o[DATA_W-1:HALF] == {HALF{result_o[HALF-1]}}));
endmodule

// File: tb/tb_bfx_unit.sv
module tb_bfx_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [63:0] src_i = '0, dst_i = '0;
  logic [4:0]  lsb_i = '0, msb_i = '0;
  logic [63:0] result_o;
  logic        wen_o, fault_o;

  int total = 0, bad = 0;
  bit done = 0;

  bit          e_valid = 0, e_fault = 0;
  logic [63:0] e_res = '0;
  string       e_tag = "R10";

  always #5 clk = ~clk;

  bfx_unit dut (.*);

  function automatic string tag_of(input logic [3:0] op, input bit f);
    case (op)
      4'd0: return f ? "R2" : "R3";
      4'd1: return "R6";
      4'd2, 4'd3, 4'd4: return f ? "R4" : "R5";
      4'd5, 4'd6, 4'd7: return f ? "R7" : "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic model(input logic [3:0] op, input logic [63:0] s, d,
                       input logic [4:0] lf, mf,
                       output logic [63:0] r, output bit f);
    int l = lf, m = mf;
    r = '0; f = 0;
    case (op)
      4'd0: begin
        f = (l + m) > 31;
        for (int i = 0; i <= m; i++) if (l + i < 64) r[i] = s[l+i];
        if (m == 31) for (int i = 32; i < 64; i++) r[i] = r[31];
      end
      4'd2, 4'd3, 4'd4: begin
        if (op == 4'd3) l += 32;
        if (op == 4'd4) m += 32;
        f = (l + m) > 63;
        for (int i = 0; i <= m; i++) if (l + i < 64) r[i] = s[l+i];
      end
      4'd1, 4'd5, 4'd6, 4'd7: begin
        if (op == 4'd6) l += 32;
        if (op == 4'd6 || op == 4'd7) m += 32;
        f = l > m;
        r = d;
        for (int i = l; i <= m; i++) r[i] = s[i-l];
        if (op == 4'd1) for (int i = 32; i < 64; i++) r[i] = r[31];
      end
      default: f = 1;
    endcase
  endtask

  task automatic chk(input string tag, input string what, input logic [63:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(e_tag, "wen", {63'd0, wen_o}, {63'd0, e_valid && !e_fault});
    chk(e_tag, "fault", {63'd0, fault_o}, {63'd0, e_valid && e_fault});
    if (e_valid && !e_fault) chk(e_tag, "result", result_o, e_res);
  endtask

  task automatic step(input bit v, input logic [3:0] op, input logic [63:0] s, d,
                      input logic [4:0] l, m);
    logic [63:0] r; bit f;
    @(negedge clk);
    compare();
    in_valid_i = v; op_i = op; src_i = s; dst_i = d; lsb_i = l; msb_i = m;
    model(op, s, d, l, m, r, f);
    e_valid = v; e_fault = f; e_res = r;
    e_tag = v ? tag_of(op, f) : "R10";
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "result", result_o, 64'd0);
    chk("R1", "wen", {63'd0, wen_o}, 64'd0);
    chk("R1", "fault", {63'd0, fault_o}, 64'd0);
    rst = 1'b0;
    // R2/R3 narrow extract
    step(1, 0, 64'h0000_0000_8765_4321, 0, 0, 31);
    step(1, 0, 64'h1234, 0, 1, 31);
    step(1, 0, 64'hFFFF_0000_ABCD_0000, 0, 16, 15);
    step(1, 0, 64'hFFFF_0000_ABCD_0000, 0, 17, 15);
    // R4/R5 wide extract with rebasing
    step(1, 4, 64'h8000_0000_0000_0001, 0, 0, 31);
    step(1, 3, 64'hDEAD_BEEF_0000_0000, 0, 0, 31);
    step(1, 3, 64'hDEAD_BEEF_0000_0000, 0, 31, 31);
    step(1, 4, 64'hDEAD_BEEF_0000_0000, 0, 1, 31);
    step(1, 2, 64'hF0F0_F0F0_F0F0_F0F0, 0, 4, 7);
    // R6 narrow insert
    step(1, 1, 64'h1, 64'h0, 31, 31);
    step(1, 1, 64'hFF, 64'hFFFF_FFFF_0000_0000, 8, 15);
    step(1, 1, 64'h0, 64'h0, 5, 4);
    // R7/R8 wide insert
    step(1, 6, 64'h3, 64'h0, 30, 31);
    step(1, 7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 5, 2);
    step(1, 5, 64'h0, 64'h0, 3, 2);
    step(1, 6, 64'h5, 64'h1234_5678_9ABC_DEF0, 4, 3);
    step(1, 5, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 0, 31);
    // R9 unused codes
    for (int c = 8; c < 16; c++) step(1, 4'(c), 64'h1, 64'h2, 0, 0);
    // R10 idle with illegal code
    step(0, 4'd9, 64'h1, 64'h2, 0, 0);
    step(0, 4'd0, 64'h1, 64'h2, 0, 0);
    // random mix
    for (int k = 0; k < 4000; k++)
      step($urandom_range(0, 7) != 0, 4'($urandom_range(0, 15)),
           {$urandom, $urandom}, {$urandom, $urandom},
           5'($urandom), 5'($urandom));
    step(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule